// File: doc/BRIEF.md
# Coherent Dual-Access Parameter RAM

This block is a small parameter memory of 16-bit words that two agents use at once: a host bus that reads and writes either single words or 32-bit long words, and a timer engine that reads and writes single words every cycle. A long word always spans an even word and the odd word above it. The even word is the low half and the odd word is the high half. When the host moves a long word, both halves are sampled at one clock edge or committed at one clock edge. Neither agent can ever observe a pair in which one half is new and the other is stale.

A mode input hands the memory to an auxiliary port with a 9-bit pair address and 32-bit data, for developing new engine functions. In that mode the host bus is locked out. Every host request still completes, but with an error response and zero data. The auxiliary port has a fixed read latency of one cycle.

The host side is run by a four-state sequencer. HS_IDLE goes to HS_EXEC when a request is sampled. HS_EXEC goes to HS_RESP_ERR when the request is rejected (emulation mode active, or a long access to an odd word address) and to HS_RESP_OK otherwise. Both response states return to HS_IDLE after one cycle. Requests that arrive while the sequencer is not in HS_IDLE are not sampled.

Top module: `prm_coherent_ram`

## Requirements
- R1: After reset every word reads as zero, and host_ack_o, host_err_o, host_rdata_o and aux_rdata_o are zero.
- R2: A host request sampled in HS_IDLE at edge k makes host_ack_o high for exactly one cycle, beginning at edge k+2. A single-word access (host_long_i=0) reads the addressed word into host_rdata_o[15:0] with the upper half zero, or writes host_wdata_i[15:0] to that word.
- R3: A host long read at an even word address a returns {word[a+1], word[a]}, with both halves sampled at edge k+1. An engine write that lands at that same edge is not visible in the result.
- R4: A host long write at an even word address a stores host_wdata_i[15:0] in word a and host_wdata_i[31:16] in word a+1, both at edge k+1.
- R5: A host long access to an odd word address completes with host_err_o=1 and host_rdata_o=0, and changes no word.
- R6: An engine write stores eng_wdata_i at eng_addr_i at the next edge. eng_rdata_o shows the word at eng_addr_i one cycle after the address is presented.
- R7: When a host long write and an engine write hit the same pair at the same edge, the host write is applied first and the engine write after it. The engine's word holds the engine data, and the other word of the pair holds its host half.
- R8: While emu_mode_i is high, every host request completes with host_err_o=1 and host_rdata_o=0, and no word changes.
- R9: While emu_mode_i is high, an auxiliary write stores aux_wdata_i[15:0] in the even word and aux_wdata_i[31:16] in the odd word of pair aux_addr_i[4:0], both at one edge. Address bits above the pair index are ignored.
- R10: While emu_mode_i is high, an auxiliary read presented in one cycle shows {odd word, even word} on aux_rdata_o in the next cycle, every time. In a cycle after one with no auxiliary read, aux_rdata_o is zero.
- R11: While emu_mode_i is low, the auxiliary port writes nothing and aux_rdata_o stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_mode_i | input | 1 | Gives the memory to the auxiliary port and locks out the host |
| host_req_i | input | 1 | Host request strobe, sampled in HS_IDLE |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_long_i | input | 1 | Host 32-bit pair access (1) or single word (0) |
| host_addr_i | input | 6 | Host word address |
| host_wdata_i | input | 32 | Host write data |
| host_ack_o | output | 1 | Host completion, one cycle |
| host_err_o | output | 1 | Host request rejected, valid with ack |
| host_rdata_o | output | 32 | Host read data, valid with ack |
| eng_we_i | input | 1 | Engine word write |
| eng_addr_i | input | 6 | Engine word address |
| eng_wdata_i | input | 16 | Engine write data |
| eng_rdata_o | output | 16 | Engine read data, one cycle after address |
| aux_req_i | input | 1 | Auxiliary access strobe |
| aux_we_i | input | 1 | Auxiliary write (1) or read (0) |
| aux_addr_i | input | 9 | Auxiliary pair address |
| aux_wdata_i | input | 32 | Auxiliary write data |
| aux_rdata_o | output | 32 | Auxiliary read data |

## Verification
If the sequencer sits in the wrong state, host_ack_o shows it on the second edge after a request: the ack arrives late, arrives early, or lasts two cycles. A word array that commits the two halves of a pair at different edges shows up on the next long read as a value that mixes old and new halves. If the collision order is wrong, the word the engine wrote carries the host's half. A mode gate that leaks lets an emulation-time host write appear on the first host read after leaving the mode, or lets aux_rdata_o go non-zero one cycle after an auxiliary read made outside the mode.

// File: rtl/prm_pkg.sv
package prm_pkg;

    localparam int WORD_W   = 16;
    localparam int LONG_W   = 32;
    localparam int AUX_AW   = 9;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_EXEC,
        HS_RESP_OK,
        HS_RESP_ERR
    } host_state_e;

endpackage

// File: rtl/prm_word_array.sv
module prm_word_array
    import prm_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_long,
    input  logic [AW-1:0]     host_wr_addr,
    input  logic [LONG_W-1:0] host_wr_data,
    input  logic [PW-1:0]     host_rd_pair,
    output logic [WORD_W-1:0] host_rd_even,
    output logic [WORD_W-1:0] host_rd_odd,
    input  logic              aux_wr_en,
    input  logic [PW-1:0]     aux_wr_pair,
    input  logic [LONG_W-1:0] aux_wr_data,
    input  logic [PW-1:0]     aux_rd_pair,
    output logic [WORD_W-1:0] aux_rd_even,
    output logic [WORD_W-1:0] aux_rd_odd,
    input  logic              eng_wr_en,
    input  logic [AW-1:0]     eng_wr_addr,
    input  logic [WORD_W-1:0] eng_wr_data,
    input  logic [AW-1:0]     eng_rd_addr,
    output logic [WORD_W-1:0] eng_rd_word
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    // Write order per word: host or auxiliary pair write first, engine last.
    always_comb begin : next_words
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (host_wr_en) begin
                if (host_wr_long) begin
                    if (host_wr_addr[AW-1:1] == PW'(i / 2)) begin
                        mem_d[i] = (i % 2 == 1) ? host_wr_data[31:16] : host_wr_data[15:0];
                    end
                end else if (host_wr_addr == AW'(i)) begin
                    mem_d[i] = host_wr_data[15:0];
                end
            end
            if (aux_wr_en && (aux_wr_pair == PW'(i / 2))) begin
                mem_d[i] = (i % 2 == 1) ? aux_wr_data[31:16] : aux_wr_data[15:0];
            end
            if (eng_wr_en && (eng_wr_addr == AW'(i))) begin
                mem_d[i] = eng_wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin : word_regs
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign host_rd_even = mem_q[{host_rd_pair, 1'b0}];
    assign host_rd_odd  = mem_q[{host_rd_pair, 1'b1}];
    assign aux_rd_even  = mem_q[{aux_rd_pair, 1'b0}];
    assign aux_rd_odd   = mem_q[{aux_rd_pair, 1'b1}];
    assign eng_rd_word  = mem_q[eng_rd_addr];

    AST_OWNER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_en && aux_wr_en)); // R8

    AST_LONG_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_long && !eng_wr_en)
        |=> (mem_q[{$past(host_wr_addr[AW-1:1]), 1'b0}] == $past(host_wr_data[15:0]))
         && (mem_q[{$past(host_wr_addr[AW-1:1]), 1'b1}] == $past(host_wr_data[31:16]))); // R4

    AST_ENGINE_AFTER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_long && eng_wr_en
         && (eng_wr_addr[AW-1:1] == host_wr_addr[AW-1:1]))
        |=> (mem_q[$past(eng_wr_addr)] == $past(eng_wr_data))
         && (mem_q[{$past(eng_wr_addr[AW-1:1]), ~$past(eng_wr_addr[0])}]
             == ($past(eng_wr_addr[0]) ? $past(host_wr_data[15:0])
                                       : $past(host_wr_data[31:16])))); // R7

endmodule

// File: rtl/prm_host_fsm.sv
module prm_host_fsm
    import prm_pkg::*;
#(
    parameter int AW = 6,
    localparam int PW = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic              long_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [LONG_W-1:0] wdata_i,
    output logic              ack_o,
    output logic              err_o,
    output logic [LONG_W-1:0] rdata_o,
    output logic              wr_en_o,
    output logic              wr_long_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [LONG_W-1:0] wr_data_o,
    output logic [PW-1:0]     rd_pair_o,
    input  logic [WORD_W-1:0] rd_even_i,
    input  logic [WORD_W-1:0] rd_odd_i
);

    host_state_e state_q, state_d;

    logic              we_q;
    logic              long_q;
    logic [AW-1:0]     addr_q;
    logic [LONG_W-1:0] wdata_q;
    logic              reject;

    assign reject = emu_i || (long_q && addr_q[0]);

    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:     if (req_i) state_d = HS_EXEC;
            HS_EXEC:     state_d = reject ? HS_RESP_ERR : HS_RESP_OK;
            HS_RESP_OK:  state_d = HS_IDLE;
            HS_RESP_ERR: state_d = HS_IDLE;
            default:     state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request is held from sampling until the sequencer is back in HS_IDLE.
    always_ff @(posedge clk) begin : request_latch
        if (!rst_n) begin
            we_q    <= 1'b0;
            long_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if ((state_q == HS_IDLE) && req_i) begin
            we_q    <= we_i;
            long_q  <= long_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Both halves of a pair are captured at the single HS_EXEC edge.
    always_ff @(posedge clk) begin : read_capture
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (state_q == HS_EXEC) begin
            if (reject || we_q) begin
                rdata_o <= '0;
            end else if (long_q) begin
                rdata_o <= {rd_odd_i, rd_even_i};
            end else begin
                rdata_o <= {{WORD_W{1'b0}}, (addr_q[0] ? rd_odd_i : rd_even_i)};
            end
        end
    end

    always_comb begin : outputs
        ack_o     = (state_q == HS_RESP_OK) || (state_q == HS_RESP_ERR);
        err_o     = (state_q == HS_RESP_ERR);
        wr_en_o   = (state_q == HS_EXEC) && we_q && !reject;
        wr_long_o = long_q;
        wr_addr_o = addr_q;
        wr_data_o = wdata_q;
        rd_pair_o = addr_q[AW-1:1];
    end

    AST_REQ_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && req_i) |=> ##1 ack_o); // R2

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R2

    AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_EXEC && long_q && addr_q[0]) |=> (err_o && rdata_o == '0)); // R5

    AST_EMU_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_EXEC && emu_i) |=> (err_o && rdata_o == '0)); // R8

endmodule

// File: rtl/prm_aux_port.sv
module prm_aux_port
    import prm_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [AUX_AW-1:0] addr_i,
    input  logic [LONG_W-1:0] wdata_i,
    output logic [LONG_W-1:0] rdata_o,
    output logic              wr_en_o,
    output logic [PW-1:0]     wr_pair_o,
    output logic [LONG_W-1:0] wr_data_o,
    output logic [PW-1:0]     rd_pair_o,
    input  logic [WORD_W-1:0] rd_even_i,
    input  logic [WORD_W-1:0] rd_odd_i
);

    logic rd_fire;
    logic unused_aux_hi;

    assign unused_aux_hi = ^addr_i[AUX_AW-1:PW];
    assign rd_fire       = emu_i && req_i && !we_i;
    assign wr_en_o       = emu_i && req_i && we_i;
    assign wr_pair_o     = addr_i[PW-1:0];
    assign rd_pair_o     = addr_i[PW-1:0];
    assign wr_data_o     = wdata_i;

    // Fixed one-cycle read pipeline, independent of host or engine traffic.
    always_ff @(posedge clk) begin : read_stage
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_fire) begin
            rdata_o <= {rd_odd_i, rd_even_i};
        end else begin
            rdata_o <= '0;
        end
    end

    AST_AUX_QUIET_OUTSIDE_EMU: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_i |=> (rdata_o == '0)); // R11

    AST_AUX_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_i && req_i && !we_i) |=> (rdata_o == {$past(rd_odd_i), $past(rd_even_i)})); // R10

endmodule

// File: rtl/prm_coherent_ram.sv
module prm_coherent_ram
    import prm_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_mode_i,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic              host_long_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [31:0]       host_wdata_i,
    output logic              host_ack_o,
    output logic              host_err_o,
    output logic [31:0]       host_rdata_o,
    input  logic              eng_we_i,
    input  logic [AW-1:0]     eng_addr_i,
    input  logic [15:0]       eng_wdata_i,
    output logic [15:0]       eng_rdata_o,
    input  logic              aux_req_i,
    input  logic              aux_we_i,
    input  logic [8:0]        aux_addr_i,
    input  logic [31:0]       aux_wdata_i,
    output logic [31:0]       aux_rdata_o
);

    logic              h_wr_en;
    logic              h_wr_long;
    logic [AW-1:0]     h_wr_addr;
    logic [LONG_W-1:0] h_wr_data;
    logic [PW-1:0]     h_rd_pair;
    logic [WORD_W-1:0] h_rd_even, h_rd_odd;
    logic              a_wr_en;
    logic [PW-1:0]     a_wr_pair, a_rd_pair;
    logic [LONG_W-1:0] a_wr_data;
    logic [WORD_W-1:0] a_rd_even, a_rd_odd;
    logic [WORD_W-1:0] e_rd_word;

    prm_host_fsm #(.AW(AW)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .emu_i     (emu_mode_i),
        .req_i     (host_req_i),
        .we_i      (host_we_i),
        .long_i    (host_long_i),
        .addr_i    (host_addr_i),
        .wdata_i   (host_wdata_i),
        .ack_o     (host_ack_o),
        .err_o     (host_err_o),
        .rdata_o   (host_rdata_o),
        .wr_en_o   (h_wr_en),
        .wr_long_o (h_wr_long),
        .wr_addr_o (h_wr_addr),
        .wr_data_o (h_wr_data),
        .rd_pair_o (h_rd_pair),
        .rd_even_i (h_rd_even),
        .rd_odd_i  (h_rd_odd)
    );

    prm_aux_port #(.PW(PW)) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .emu_i     (emu_mode_i),
        .req_i     (aux_req_i),
        .we_i      (aux_we_i),
        .addr_i    (aux_addr_i),
        .wdata_i   (aux_wdata_i),
        .rdata_o   (aux_rdata_o),
        .wr_en_o   (a_wr_en),
        .wr_pair_o (a_wr_pair),
        .wr_data_o (a_wr_data),
        .rd_pair_o (a_rd_pair),
        .rd_even_i (a_rd_even),
        .rd_odd_i  (a_rd_odd)
    );

    prm_word_array #(.DEPTH(DEPTH)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (h_wr_en),
        .host_wr_long (h_wr_long),
        .host_wr_addr (h_wr_addr),
        .host_wr_data (h_wr_data),
        .host_rd_pair (h_rd_pair),
        .host_rd_even (h_rd_even),
        .host_rd_odd  (h_rd_odd),
        .aux_wr_en    (a_wr_en),
        .aux_wr_pair  (a_wr_pair),
        .aux_wr_data  (a_wr_data),
        .aux_rd_pair  (a_rd_pair),
        .aux_rd_even  (a_rd_even),
        .aux_rd_odd   (a_rd_odd),
        .eng_wr_en    (eng_we_i),
        .eng_wr_addr  (eng_addr_i),
        .eng_wr_data  (eng_wdata_i),
        .eng_rd_addr  (eng_addr_i),
        .eng_rd_word  (e_rd_word)
    );

    always_ff @(posedge clk) begin : engine_read_stage
        if (!rst_n) begin
            eng_rdata_o <= '0;
        end else begin
            eng_rdata_o <= e_rd_word;
        end
    end

    AST_ENGINE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we_i && !h_wr_en && !a_wr_en) ##1 ($past(eng_addr_i) == eng_addr_i)
        |=> (eng_rdata_o == $past(eng_wdata_i, 2))); // R6

endmodule

// File: tb/tb_prm_coherent_ram.sv
`timescale 1ns/1ps
module tb_prm_coherent_ram;

    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        emu_mode;
    logic        host_req, host_we, host_long;
    logic [AW-1:0] host_addr;
    logic [31:0] host_wdata;
    logic        host_ack, host_err;
    logic [31:0] host_rdata;
    logic        eng_we;
    logic [AW-1:0] eng_addr;
    logic [15:0] eng_wdata;
    logic [15:0] eng_rdata;
    logic        aux_req, aux_we;
    logic [8:0]  aux_addr;
    logic [31:0] aux_wdata;
    logic [31:0] aux_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    logic [15:0] model [DEPTH];

    always #4 clk = ~clk;

    prm_coherent_ram #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .emu_mode_i(emu_mode),
        .host_req_i(host_req), .host_we_i(host_we), .host_long_i(host_long),
        .host_addr_i(host_addr), .host_wdata_i(host_wdata),
        .host_ack_o(host_ack), .host_err_o(host_err), .host_rdata_o(host_rdata),
        .eng_we_i(eng_we), .eng_addr_i(eng_addr), .eng_wdata_i(eng_wdata),
        .eng_rdata_o(eng_rdata),
        .aux_req_i(aux_req), .aux_we_i(aux_we), .aux_addr_i(aux_addr),
        .aux_wdata_i(aux_wdata), .aux_rdata_o(aux_rdata)
    );

    function automatic logic [15:0] pat_a(input int i);
        return 16'((i * 16'h1357) + 16'h0A0F);
    endfunction

    function automatic logic [31:0] pat_b(input int p);
        return 32'((p * 32'h0102_0304) ^ 32'h5A5A_C3C3);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // Host access; optional engine write driven during the HS_EXEC cycle.
    task automatic host_op(input logic we, input logic lng, input logic [AW-1:0] a,
                           input logic [31:0] wd, input logic ce,
                           input logic [AW-1:0] ca, input logic [15:0] cd,
                           output logic [31:0] rd, output logic er);
        logic early;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_long = lng; host_addr = a; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        early = host_ack;
        eng_we = ce; eng_addr = ca; eng_wdata = cd;
        @(negedge clk);
        eng_we = 1'b0;
        check(!early && host_ack, "R2 ack timing", {30'd0, early, host_ack}, 32'd1);
        rd = host_rdata;
        er = host_err;
        @(negedge clk);
        check(!host_ack, "R2 ack width", {31'd0, host_ack}, 32'd0);
    endtask

    task automatic eng_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        eng_we = 1'b1; eng_addr = a; eng_wdata = d;
        @(negedge clk);
        eng_we = 1'b0;
    endtask

    task automatic eng_read(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        eng_addr = a;
        @(negedge clk);
        d = eng_rdata;
    endtask

    task automatic aux_op(input logic we, input logic [8:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        @(negedge clk);
        aux_req = 1'b1; aux_we = we; aux_addr = a; aux_wdata = wd;
        @(negedge clk);
        aux_req = 1'b0; aux_we = 1'b0;
        rd = aux_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] w;
        logic        er;

        rst_n = 1'b0; emu_mode = 1'b0;
        host_req = 0; host_we = 0; host_long = 0; host_addr = '0; host_wdata = '0;
        eng_we = 0; eng_addr = '0; eng_wdata = '0;
        aux_req = 0; aux_we = 0; aux_addr = '0; aux_wdata = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(host_ack == 0 && host_err == 0, "R1 ack/err", {30'd0, host_ack, host_err}, 32'd0);
        check(host_rdata == 0, "R1 host rdata", host_rdata, 32'd0);
        check(aux_rdata == 0, "R1 aux rdata", aux_rdata, 32'd0);
        for (int i = 0; i < DEPTH; i += 9) begin
            eng_read(AW'(i), w);
            check(w == 0, "R1 word zero", {16'd0, w}, 32'd0);
        end

        // R6 engine write sweep, read back through the engine
        for (int i = 0; i < DEPTH; i++) begin
            eng_write(AW'(i), pat_a(i));
            model[i] = pat_a(i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            eng_read(AW'(i), w);
            check(w == model[i], "R6 engine read", {16'd0, w}, {16'd0, model[i]});
        end

        // R2 host single-word read sweep
        for (int i = 0; i < DEPTH; i++) begin
            host_op(0, 0, AW'(i), '0, 0, '0, '0, rd, er);
            check(!er && rd == {16'd0, model[i]}, "R2 short read", rd, {16'd0, model[i]});
        end

        // R3 host long read sweep
        for (int p = 0; p < DEPTH / 2; p++) begin
            host_op(0, 1, AW'(2 * p), '0, 0, '0, '0, rd, er);
            check(!er && rd == {model[2*p+1], model[2*p]}, "R3 long read",
                  rd, {model[2*p+1], model[2*p]});
        end

        // R4 host long write sweep, checked word by word via the engine
        for (int p = 0; p < DEPTH / 2; p++) begin
            host_op(1, 1, AW'(2 * p), pat_b(p), 0, '0, '0, rd, er);
            check(!er, "R4 long write accepted", {31'd0, er}, 32'd0);
            model[2*p]   = pat_b(p)[15:0];
            model[2*p+1] = pat_b(p)[31:16];
        end
        for (int i = 0; i < DEPTH; i++) begin
            eng_read(AW'(i), w);
            check(w == model[i], "R4 pair halves", {16'd0, w}, {16'd0, model[i]});
        end

        // R2 single-word writes at even and odd addresses
        for (int i = 30; i < 34; i++) begin
            host_op(1, 0, AW'(i), {16'hFFFF, 16'(16'h7100 + i)}, 0, '0, '0, rd, er);
            model[i] = 16'(16'h7100 + i);
        end
        for (int i = 29; i < 35; i++) begin
            host_op(0, 0, AW'(i), '0, 0, '0, '0, rd, er);
            check(rd == {16'd0, model[i]}, "R2 short write", rd, {16'd0, model[i]});
        end

        // R5 misaligned long write and read
        host_op(1, 1, AW'(7), 32'hDEAD_BEEF, 0, '0, '0, rd, er);
        check(er && rd == 0, "R5 misaligned write", {er, rd[30:0]}, 32'h8000_0000);
        host_op(0, 1, AW'(13), '0, 0, '0, '0, rd, er);
        check(er && rd == 0, "R5 misaligned read", {er, rd[30:0]}, 32'h8000_0000);
        for (int i = 6; i < 9; i++) begin
            eng_read(AW'(i), w);
            check(w == model[i], "R5 memory unchanged", {16'd0, w}, {16'd0, model[i]});
        end

        // R3 coherent capture: engine write to the odd half at the capture edge
        host_op(0, 1, AW'(8), '0, 1, AW'(9), 16'h9999, rd, er);
        check(rd == {model[9], model[8]}, "R3 coherent snapshot", rd, {model[9], model[8]});
        model[9] = 16'h9999;
        host_op(0, 1, AW'(8), '0, 0, '0, '0, rd, er);
        check(rd == {model[9], model[8]}, "R3 later read", rd, {model[9], model[8]});

        // R7 collision: host long write and engine write to the same pair
        host_op(1, 1, AW'(20), 32'h1111_2222, 1, AW'(20), 16'hBEEF, rd, er);
        model[20] = 16'hBEEF; model[21] = 16'h1111;
        host_op(0, 1, AW'(20), '0, 0, '0, '0, rd, er);
        check(rd == 32'h1111_BEEF, "R7 engine after host even", rd, 32'h1111_BEEF);
        host_op(1, 1, AW'(22), 32'h3333_4444, 1, AW'(23), 16'hF00D, rd, er);
        model[22] = 16'h4444; model[23] = 16'hF00D;
        host_op(0, 1, AW'(22), '0, 0, '0, '0, rd, er);
        check(rd == 32'hF00D_4444, "R7 engine after host odd", rd, 32'hF00D_4444);

        // R8 emulation locks out the host
        @(negedge clk);
        emu_mode = 1'b1;
        host_op(1, 1, AW'(4), 32'h0BAD_0BAD, 0, '0, '0, rd, er);
        check(er && rd == 0, "R8 host write rejected", {er, rd[30:0]}, 32'h8000_0000);
        host_op(1, 0, AW'(5), 32'h0000_0BAD, 0, '0, '0, rd, er);
        check(er && rd == 0, "R8 host short write rejected", {er, rd[30:0]}, 32'h8000_0000);
        host_op(0, 0, AW'(6), '0, 0, '0, '0, rd, er);
        check(er && rd == 0, "R8 host read rejected", {er, rd[30:0]}, 32'h8000_0000);

        // R10 auxiliary read sweep of all pairs
        for (int p = 0; p < DEPTH / 2; p++) begin
            aux_op(0, 9'(p), '0, rd);
            check(rd == {model[2*p+1], model[2*p]}, "R10 aux read", rd, {model[2*p+1], model[2*p]});
        end
        @(negedge clk);
        check(aux_rdata == 0, "R10 aux idle zero", aux_rdata, 32'd0);

        // R9 auxiliary writes, including upper address bits set
        aux_op(1, 9'd12, 32'hCAFE_F00D, rd);
        model[24] = 16'hF00D; model[25] = 16'hCAFE;
        aux_op(0, 9'h0EC, '0, rd);
        check(rd == 32'hCAFE_F00D, "R9 aux write, high bits ignored", rd, 32'hCAFE_F00D);
        aux_op(1, 9'h1E3, 32'h7654_3210, rd);
        model[6] = 16'h3210; model[7] = 16'h7654;
        aux_op(0, 9'd3, '0, rd);
        check(rd == 32'h7654_3210, "R9 aux write aliased pair", rd, 32'h7654_3210);

        // R11 auxiliary port inert outside emulation
        @(negedge clk);
        emu_mode = 1'b0;
        aux_op(1, 9'd0, 32'hAAAA_5555, rd);
        aux_op(0, 9'd0, '0, rd);
        check(rd == 0, "R11 aux rdata zero", rd, 32'd0);
        host_op(0, 1, AW'(0), '0, 0, '0, '0, rd, er);
        check(!er && rd == {model[1], model[0]}, "R11 aux write ignored", rd, {model[1], model[0]});

        // R8 host writes during emulation left no trace
        host_op(0, 1, AW'(4), '0, 0, '0, '0, rd, er);
        check(!er && rd == {model[5], model[4]}, "R8 pair unchanged", rd, {model[5], model[4]});
        host_op(0, 1, AW'(24), '0, 0, '0, '0, rd, er);
        check(rd == 32'hCAFE_F00D, "R9 host sees aux data", rd, 32'hCAFE_F00D);

        finish_run();
    end

endmodule